// File: doc/BRIEF.md
# Multi-Sector Disk Transfer Sequencer

This block holds the task file of a fixed-disk controller and steps a read or write command across consecutive sectors. A CPU-style write port loads six registers: the sector count, the starting sector number, two cylinder bytes, a packed size/drive/head byte and the command. Writing the command while idle starts the sequence. The block checks that the request is one it can serve. It emits a one-cycle transfer-start strobe together with the linear block address, then waits for a one-cycle sector-done input from the media side.

When the multiple-sector flag is set, each completed sector decrements the count. If the new count is still greater than one, the sector number is advanced. The command is then re-issued after a fixed 100 µs pause, which is counted in clock cycles. The final completion lowers busy and pulses an interrupt. Requests for a sector size other than 256 bytes, for a drive other than 0, or for a sector number above 32 complete without a transfer and raise a failure flag.

Top module: `disk_xfer_seq`

## Requirements
- R1: Writes at offset 2 (count), 3 (sector), 4 (cylinder low byte), 5 (cylinder high byte), 6 (size/drive/head) and 7 (command) load that register, and `bus_rdata` returns it at the same `bus_addr`. Offsets 0 and 1 store nothing and read as 0.
- R2: Reset clears count, sector, size/drive/head and command, together with all outputs. It leaves both cylinder bytes unchanged.
- R3: A command write while idle sets `busy` after that clock edge. For a command whose upper nibble is 0x2 (read) or 0x3 (write), `xfer_start` pulses one cycle later. In that cycle `xfer_is_write` is 0 for a read and 1 for a write.
- R4: In the size/drive/head byte, bits 6:5 code the sector size (0=256, 1=512, 2=1024, 3=128 bytes), bits 4:3 the drive and bits 2:0 the head. A transfer is issued only for drive 0 with size code 0. Any other request completes without `xfer_start` and sets `req_fail`.
- R5: A sector number above 32 issues no transfer, completes the command and sets `req_fail`. This also applies when the sector number has been advanced past 32 during a multi-sector run.
- R6: With command bit 2 clear, one sector is transferred. The next `sector_done` completes the command and leaves the count unchanged.
- R7: With command bit 2 set, each `sector_done` decrements the count. If the result exceeds 1, the sector number is incremented and the command is re-issued. Otherwise the command completes, so a count of N ≥ 2 yields N−1 sectors.
- R8: `xfer_start` for a re-issued sector rises D+1 cycles after the cycle in which `sector_done` was sampled, where D = CLK_HZ·100/10^6.
- R9: `lba` equals (cylinder·HEADS + head)·SPT + sector, computed from the current registers.
- R10: At completion, `busy` falls and `done_irq` is high for exactly that one cycle.
- R11: While busy, every register write is ignored. A command write additionally sets `cmd_overrun`, which holds until the next accepted command write clears it.
- R12: A command with any other upper nibble completes one cycle after acceptance, with no transfer and with `req_fail` clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register offset for write and read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Register read data at `bus_addr` |
| sector_done | input | 1 | One-cycle pulse: current sector finished |
| busy | output | 1 | Command in progress |
| xfer_start | output | 1 | One-cycle pulse: begin a sector transfer |
| xfer_is_write | output | 1 | Direction of the current transfer |
| lba | output | LBA_W | Linear block address of the current sector |
| done_irq | output | 1 | One-cycle completion pulse |
| req_fail | output | 1 | Last command was rejected |
| cmd_overrun | output | 1 | A command was written while busy |

## Verification
The checks assume that `sector_done` arrives only while a transfer is outstanding, meaning after `xfer_start` and before completion. They also assume that no two pulses of it are sent for one sector. The directed tasks honour this by raising `sector_done` only after they have seen `xfer_start`, and only once per observed start. Bus writes are single-cycle strobes driven away from the clock edge. The count is never loaded with 0 for a multi-sector command, because its wrap-around would produce a run far longer than the bench.

// File: rtl/dxs_pkg.sv
package dxs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_GAP   = 2'd3
  } seq_state_e;

  localparam logic [2:0] OFF_COUNT  = 3'd2;
  localparam logic [2:0] OFF_SECTOR = 3'd3;
  localparam logic [2:0] OFF_CYL_LO = 3'd4;
  localparam logic [2:0] OFF_CYL_HI = 3'd5;
  localparam logic [2:0] OFF_SDH    = 3'd6;
  localparam logic [2:0] OFF_CMD    = 3'd7;

  localparam logic [3:0] OP_READ  = 4'h2;
  localparam logic [3:0] OP_WRITE = 4'h3;

  // bytes per sector for the two-bit size code
  function automatic int sector_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 256;
      2'd1:    return 512;
      2'd2:    return 1024;
      default: return 128;
    endcase
  endfunction

  // linear block address from geometry
  function automatic logic [63:0] calc_lba(input logic [15:0] cyl,
                                           input logic [2:0]  head,
                                           input logic [7:0]  sec,
                                           input int          heads,
                                           input int          spt);
    logic [63:0] track;
    track = 64'(cyl) * 64'(heads) + 64'(head);
    return track * 64'(spt) + 64'(sec);
  endfunction

endpackage

// File: rtl/dxs_taskfile.sv
module dxs_taskfile
  import dxs_pkg::*;
#(
  parameter int SEC_MAX = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  addr,
  input  logic [7:0]  wdata,
  input  logic        cnt_dec,
  input  logic        sec_inc,
  output logic [7:0]  count_q,
  output logic [7:0]  sector_q,
  output logic [15:0] cyl_q,
  output logic [7:0]  sdh_q,
  output logic [7:0]  cmd_q,
  output logic [7:0]  rdata,
  output logic        xfer_ok,
  output logic        sec_ok
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q  <= '0;
      sector_q <= '0;
      sdh_q    <= '0;
      cmd_q    <= '0;
    end else begin
      if (wr_en && addr == OFF_COUNT)  count_q  <= wdata;
      else if (cnt_dec)                count_q  <= count_q - 8'd1;
      if (wr_en && addr == OFF_SECTOR) sector_q <= wdata;
      else if (sec_inc)                sector_q <= sector_q + 8'd1;
      if (wr_en && addr == OFF_SDH)    sdh_q    <= wdata;
      if (wr_en && addr == OFF_CMD)    cmd_q    <= wdata;
    end
  end

  // cylinder bytes survive reset
  always_ff @(posedge clk) begin
    if (wr_en && addr == OFF_CYL_LO) cyl_q[7:0]  <= wdata;
    if (wr_en && addr == OFF_CYL_HI) cyl_q[15:8] <= wdata;
  end

  always_comb begin
    case (addr)
      OFF_COUNT:  rdata = count_q;
      OFF_SECTOR: rdata = sector_q;
      OFF_CYL_LO: rdata = cyl_q[7:0];
      OFF_CYL_HI: rdata = cyl_q[15:8];
      OFF_SDH:    rdata = sdh_q;
      OFF_CMD:    rdata = cmd_q;
      default:    rdata = '0;
    endcase
  end

  assign xfer_ok = (sdh_q[4:3] == 2'd0) && (sector_bytes(sdh_q[6:5]) == 256);
  assign sec_ok  = (sector_q <= 8'(SEC_MAX));

endmodule

// File: rtl/dxs_gap_timer.sv
module dxs_gap_timer #(
  parameter int GAP_CYC = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expire
);

  localparam int CYC   = (GAP_CYC < 1) ? 1 : GAP_CYC;
  localparam int CNT_W = (CYC < 2) ? 1 : $clog2(CYC);

  logic             running;
  logic [CNT_W-1:0] cnt;

  assign expire = running && (cnt == CNT_W'(CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (start) begin
      running <= 1'b1;
      cnt     <= '0;
    end else if (expire) begin
      running <= 1'b0;
    end else if (running) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/dxs_ctrl.sv
module dxs_ctrl
  import dxs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_accept,
  input  logic       cmd_busy,
  input  logic [3:0] op_nib,
  input  logic       multi,
  input  logic       xfer_ok,
  input  logic       sec_ok,
  input  logic [7:0] count_q,
  input  logic       sector_done,
  input  logic       gap_expire,
  output logic       busy,
  output logic       xfer_start,
  output logic       xfer_write,
  output logic       done_irq,
  output logic       req_fail,
  output logic       overrun,
  output logic       gap_start,
  output logic       cnt_dec,
  output logic       sec_inc
);

  seq_state_e state;
  logic       is_xfer, go_on, wait_done;

  assign is_xfer   = (op_nib == OP_READ) || (op_nib == OP_WRITE);
  assign wait_done = (state == ST_WAIT) && sector_done;
  assign go_on     = (count_q - 8'd1) > 8'd1;
  assign cnt_dec   = wait_done && multi;
  assign sec_inc   = cnt_dec && go_on;
  assign gap_start = sec_inc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      busy       <= 1'b0;
      xfer_start <= 1'b0;
      xfer_write <= 1'b0;
      done_irq   <= 1'b0;
      req_fail   <= 1'b0;
      overrun    <= 1'b0;
    end else begin
      xfer_start <= 1'b0;
      done_irq   <= 1'b0;
      if (cmd_busy) overrun <= 1'b1;
      case (state)
        ST_IDLE: if (cmd_accept) begin
          state    <= ST_ISSUE;
          busy     <= 1'b1;
          req_fail <= 1'b0;
          overrun  <= 1'b0;
        end
        ST_ISSUE: if (is_xfer && xfer_ok && sec_ok) begin
          state      <= ST_WAIT;
          xfer_start <= 1'b1;
          xfer_write <= (op_nib == OP_WRITE);
        end else begin
          state    <= ST_IDLE;
          busy     <= 1'b0;
          done_irq <= 1'b1;
          req_fail <= is_xfer;
        end
        ST_WAIT: if (sector_done) begin
          if (sec_inc) begin
            state <= ST_GAP;
          end else begin
            state    <= ST_IDLE;
            busy     <= 1'b0;
            done_irq <= 1'b1;
          end
        end
        ST_GAP: if (gap_expire) state <= ST_ISSUE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/disk_xfer_seq.sv
module disk_xfer_seq
  import dxs_pkg::*;
#(
  parameter int CLK_HZ   = 50_000_000,
  parameter int DELAY_US = 100,
  parameter int HEADS    = 8,
  parameter int SPT      = 32,
  parameter int SEC_MAX  = 32,
  parameter int LBA_W    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [2:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic             sector_done,
  output logic             busy,
  output logic             xfer_start,
  output logic             xfer_is_write,
  output logic [LBA_W-1:0] lba,
  output logic             done_irq,
  output logic             req_fail,
  output logic             cmd_overrun
);

  localparam int GAP_CYC = (CLK_HZ / 1000) * DELAY_US / 1000;

  logic        wr_en, cmd_accept, cmd_busy;
  logic        cnt_dec, sec_inc, gap_start, gap_expire;
  logic        xfer_ok, sec_ok;
  logic [7:0]  count_q, sector_q, sdh_q, cmd_q;
  logic [15:0] cyl_q;
  logic [63:0] lba_full;

  assign wr_en      = bus_we && !busy;
  assign cmd_accept = wr_en && (bus_addr == OFF_CMD);
  assign cmd_busy   = bus_we && busy && (bus_addr == OFF_CMD);

  dxs_taskfile #(.SEC_MAX(SEC_MAX)) u_tf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(bus_addr),
    .wdata(bus_wdata), .cnt_dec(cnt_dec), .sec_inc(sec_inc),
    .count_q(count_q), .sector_q(sector_q), .cyl_q(cyl_q),
    .sdh_q(sdh_q), .cmd_q(cmd_q), .rdata(bus_rdata),
    .xfer_ok(xfer_ok), .sec_ok(sec_ok)
  );

  dxs_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk(clk), .rst_n(rst_n), .start(gap_start), .expire(gap_expire)
  );

  dxs_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_accept(cmd_accept), .cmd_busy(cmd_busy),
    .op_nib(cmd_q[7:4]), .multi(cmd_q[2]), .xfer_ok(xfer_ok), .sec_ok(sec_ok),
    .count_q(count_q), .sector_done(sector_done), .gap_expire(gap_expire),
    .busy(busy), .xfer_start(xfer_start), .xfer_write(xfer_is_write),
    .done_irq(done_irq), .req_fail(req_fail), .overrun(cmd_overrun),
    .gap_start(gap_start), .cnt_dec(cnt_dec), .sec_inc(sec_inc)
  );

  assign lba_full = calc_lba(cyl_q, sdh_q[2:0], sector_q, HEADS, SPT);
  assign lba      = lba_full[LBA_W-1:0];

endmodule

// File: rtl/dxs_checker.sv
module dxs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_we,
  input logic [2:0] bus_addr,
  input logic       busy,
  input logic       xfer_start,
  input logic       done_irq,
  input logic       cmd_overrun,
  input logic       cnt_dec,
  input logic       sec_inc,
  input logic [7:0] count_q,
  input logic [7:0] sector_q,
  input logic       xfer_ok,
  input logic       sec_ok
);

  // R10
  busy_fall_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_irq);

  // R10
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> !busy);

  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> busy);

  // R4
  start_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> $past(xfer_ok && sec_ok));

  // R7
  sector_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_inc |=> sector_q == $past(sector_q) + 8'd1);

  // R7
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_dec |=> count_q == $past(count_q) - 8'd1);

  // R11
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && busy && bus_addr == 3'd7) |=> cmd_overrun);

endmodule

bind disk_xfer_seq dxs_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .busy(busy), .xfer_start(xfer_start), .done_irq(done_irq),
  .cmd_overrun(cmd_overrun), .cnt_dec(cnt_dec), .sec_inc(sec_inc),
  .count_q(count_q), .sector_q(sector_q), .xfer_ok(xfer_ok), .sec_ok(sec_ok)
);

// File: tb/disk_xfer_seq_test.sv
module disk_xfer_seq_test;

  localparam int TB_HZ = 200_000;
  localparam int HEADS = 8;
  localparam int SPT   = 32;
  localparam int D     = TB_HZ * 100 / 1_000_000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        sector_done = 1'b0;
  logic        busy, xfer_start, xfer_is_write, done_irq, req_fail, cmd_overrun;
  logic [31:0] lba;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  disk_xfer_seq #(.CLK_HZ(TB_HZ), .HEADS(HEADS), .SPT(SPT)) uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sector_done(sector_done),
    .busy(busy), .xfer_start(xfer_start), .xfer_is_write(xfer_is_write),
    .lba(lba), .done_irq(done_irq), .req_fail(req_fail),
    .cmd_overrun(cmd_overrun)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic pulse_done();
    @(negedge clk);
    sector_done = 1'b1;
    @(negedge clk);
    sector_done = 1'b0;
  endtask

  // negedges until xfer_start is seen, bounded
  task automatic wait_start(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!xfer_start && n < 4 * D + 10);
  endtask

  function automatic longint exp_lba(int cyl, int head, int sec);
    return longint'((cyl * HEADS + head) * SPT + sec);
  endfunction

  task automatic t_reset();
    logic [7:0] v;
    chk("R2 busy after reset", busy, 0);
    chk("R2 irq after reset", done_irq, 0);
    chk("R2 fail after reset", req_fail, 0);
    rd(3'd2, v); chk("R2 count after reset", v, 0);
    rd(3'd7, v); chk("R2 cmd after reset", v, 0);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    wr(3'd0, 8'h5A); wr(3'd1, 8'hA5);
    wr(3'd2, 8'h11); wr(3'd3, 8'h22); wr(3'd4, 8'h33);
    wr(3'd5, 8'h44); wr(3'd6, 8'h85);
    rd(3'd0, v); chk("R1 offset0", v, 0);
    rd(3'd1, v); chk("R1 offset1", v, 0);
    rd(3'd2, v); chk("R1 count", v, 8'h11);
    rd(3'd3, v); chk("R1 sector", v, 8'h22);
    rd(3'd4, v); chk("R1 cyl lo", v, 8'h33);
    rd(3'd5, v); chk("R1 cyl hi", v, 8'h44);
    rd(3'd6, v); chk("R1 sdh", v, 8'h85);
    chk("R9 lba", lba, exp_lba(16'h4433, 5, 8'h22));
  endtask

  task automatic t_single_read();
    int n;
    logic [7:0] v;
    wr(3'd4, 8'h02); wr(3'd5, 8'h01); wr(3'd6, 8'h05);
    wr(3'd3, 8'd3); wr(3'd2, 8'd9);
    wr(3'd7, 8'h20);
    chk("R3 busy after cmd", busy, 1);
    chk("R3 no start yet", xfer_start, 0);
    wait_start(n);
    chk("R3 start latency", n, 1);
    chk("R3 read dir", xfer_is_write, 0);
    chk("R9 lba single", lba, exp_lba(258, 5, 3));
    pulse_done();
    chk("R10 busy drop", busy, 0);
    chk("R10 irq", done_irq, 1);
    chk("R6 no fail", req_fail, 0);
    rd(3'd2, v); chk("R6 count kept", v, 9);
    @(negedge clk);
    chk("R10 irq one cycle", done_irq, 0);
  endtask

  task automatic t_multi_write();
    int n;
    logic [7:0] v;
    wr(3'd6, 8'h02); wr(3'd3, 8'd5); wr(3'd2, 8'd4);
    wr(3'd7, 8'h34);
    for (int i = 0; i < 3; i++) begin
      wait_start(n);
      if (i == 0) chk("R3 first start", n, 1);
      else        chk("R8 restart delay", n, D + 1);
      chk("R3 write dir", xfer_is_write, 1);
      rd(3'd3, v); chk("R7 sector step", v, 5 + i);
      chk("R9 lba multi", lba, exp_lba(258, 2, 5 + i));
      pulse_done();
      if (i < 2) chk("R7 still busy", busy, 1);
    end
    chk("R7 done busy", busy, 0);
    chk("R10 multi irq", done_irq, 1);
    rd(3'd2, v); chk("R7 final count", v, 1);
    rd(3'd3, v); chk("R7 final sector", v, 7);
  endtask

  task automatic t_multi_two();
    int n;
    logic [7:0] v;
    wr(3'd3, 8'd10); wr(3'd2, 8'd2);
    wr(3'd7, 8'h24);
    wait_start(n);
    chk("R3 start", n, 1);
    pulse_done();
    chk("R7 count2 one sector", busy, 0);
    chk("R7 count2 irq", done_irq, 1);
    rd(3'd2, v); chk("R7 count2 count", v, 1);
    rd(3'd3, v); chk("R7 count2 sector", v, 10);
  endtask

  task automatic t_bad_geom();
    wr(3'd3, 8'd1);
    wr(3'd6, 8'h20);
    wr(3'd7, 8'h20);
    @(negedge clk);
    chk("R4 size512 no start", xfer_start, 0);
    chk("R4 size512 done", done_irq, 1);
    chk("R4 size512 fail", req_fail, 1);
    chk("R4 size512 idle", busy, 0);
    wr(3'd6, 8'h08);
    wr(3'd7, 8'h30);
    @(negedge clk);
    chk("R4 drive1 no start", xfer_start, 0);
    chk("R4 drive1 fail", req_fail, 1);
    chk("R4 drive1 done", done_irq, 1);
  endtask

  task automatic t_bad_sector();
    int n;
    wr(3'd6, 8'h00); wr(3'd3, 8'd33);
    wr(3'd7, 8'h20);
    @(negedge clk);
    chk("R5 sec33 no start", xfer_start, 0);
    chk("R5 sec33 fail", req_fail, 1);
    chk("R5 sec33 done", done_irq, 1);
    wr(3'd3, 8'd32); wr(3'd2, 8'd4);
    wr(3'd7, 8'h24);
    chk("R5 fail cleared", req_fail, 0);
    wait_start(n);
    chk("R5 sec32 start", n, 1);
    pulse_done();
    repeat (D + 1) @(negedge clk);
    chk("R5 runoff no start", xfer_start, 0);
    chk("R5 runoff done", done_irq, 1);
    chk("R5 runoff fail", req_fail, 1);
    chk("R5 runoff idle", busy, 0);
  endtask

  task automatic t_overrun();
    int n;
    logic [7:0] v;
    wr(3'd3, 8'd4); wr(3'd2, 8'd7);
    wr(3'd7, 8'h20);
    wait_start(n);
    wr(3'd7, 8'h30);
    wr(3'd3, 8'd9);
    chk("R11 overrun", cmd_overrun, 1);
    rd(3'd7, v); chk("R11 cmd kept", v, 8'h20);
    rd(3'd3, v); chk("R11 sector kept", v, 4);
    pulse_done();
    chk("R11 overrun held", cmd_overrun, 1);
    wr(3'd7, 8'h70);
    chk("R11 overrun cleared", cmd_overrun, 0);
    @(negedge clk);
    chk("R12 other done", done_irq, 1);
    chk("R12 other no fail", req_fail, 0);
    chk("R12 other idle", busy, 0);
  endtask

  task automatic t_reset_cyl();
    logic [7:0] v;
    wr(3'd4, 8'hAB); wr(3'd5, 8'hCD); wr(3'd2, 8'd5);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(3'd4, v); chk("R2 cyl lo kept", v, 8'hAB);
    rd(3'd5, v); chk("R2 cyl hi kept", v, 8'hCD);
    rd(3'd2, v); chk("R2 count cleared", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_single_read();
    t_multi_write();
    t_multi_two();
    t_bad_geom();
    t_bad_sector();
    t_overrun();
    t_reset_cyl();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100_000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule